// File: doc/BRIEF.md
# Multi-Port Schedule Base Alignment Unit

This unit takes the gate-schedule descriptors of a set of egress ports and works out whether they can all be started from one common operational start time. Each descriptor holds a valid bit, a start time in nanoseconds and a cycle length in nanoseconds. After a start pulse the unit walks the ports one per clock through a combinational read port, keeps running extremes, then uses a shared serial divider to align the earliest schedule to the latest one and to compute each port's entry offset.

The results are an enable flag, the aligned common start time, the longest cycle length, a span error when the ports lie too far apart to share a start, and one entry offset per port counted in 200 ns steps. Every offset is biased by one step, so the port that starts first receives 1 and no valid port ever receives 0. The descriptor source must keep the addressed descriptor stable while `busy` is high, and every valid descriptor must carry a non-zero cycle length.

Top module: `base_time_aligner`

## Requirements
- R1: A `start` pulse seen while idle raises `busy` on the next cycle, and `done` is high for exactly one cycle at the end of the run. `busy` falls on the cycle after `done`. A `start` pulse seen while busy has no effect: the run produces one `done` only.
- R2: A port whose descriptor has `rd_valid` low has no effect on any result. `enabled` is 1 when at least one port is valid.
- R3: When no port is valid, the run still ends with `done`, and `enabled`, `range_err`, `earliest_base`, `max_cycle` and all entry offsets are 0.
- R4: `max_cycle` equals the largest cycle length among the valid ports.
- R5: The earliest port is the valid port with the smallest start time. When two ports share that smallest start time, the port with the lower index supplies the cycle length that is used for alignment.
- R6: `earliest_base` is the largest value of the form E + k·C that is not greater than L. Here E and C are the earliest port's start time and cycle length, L is the latest valid start time, and k ≥ 0.
- R7: `range_err` is 1 exactly when L − `earliest_base` is greater than 2^19 · 200 ns. A difference equal to that limit is not an error. When the error is set, all entry offsets are 0.
- R8: When no error is set, the offset of each valid port p is floor(R/200) + 1. R is the port's start time advanced by whole cycle lengths to the first value at or after `earliest_base`, minus `earliest_base`. An invalid port gets 0, and the earliest port gets 1.
- R9: The offset of port p is placed in bits [p·TW +: TW] of `entry_deltas`. All results hold their values from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| rd_idx | output | $clog2(NPORT) | Port index of the descriptor being read |
| rd_valid | input | 1 | Descriptor at rd_idx is valid |
| rd_base | input | TW | Start time of descriptor at rd_idx, ns |
| rd_cycle | input | TW | Cycle length of descriptor at rd_idx, ns |
| enabled | output | 1 | At least one valid port |
| range_err | output | 1 | Ports too far apart for one common start |
| earliest_base | output | TW | Aligned common start time, ns |
| max_cycle | output | TW | Longest valid cycle length, ns |
| entry_deltas | output | NPORT·TW | Per-port entry offsets in 200 ns steps |

## Verification
The bench aims at the alignment corner cases. It covers a latest start that is an exact multiple of cycles past the earliest one, so the remainder is zero and a wrong design would step back one cycle too far. It covers ports that start after the aligned time and therefore need no roll, and equal earliest start times, where a wrong tie-break would align with the wrong cycle. It also puts the span exactly at the error limit and one nanosecond beyond it, where an off-by-one comparison would flag the error too early or too late. The remaining cases are the run with no valid ports and a second start pulse during a run; a design that got these wrong would report stale results or raise `done` twice.

// File: rtl/bta_pkg.sv
package bta_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SCAN_END,
        ST_ALIGN,
        ST_PORT,
        ST_ROLL,
        ST_QUANT,
        ST_DONE
    } bta_state_e;

    // Largest permitted distance between aligned and latest start, in ns.
    function automatic longint unsigned span_limit_ns(input int unsigned log2_steps,
                                                      input int unsigned step_ns);
        return (64'd1 << log2_steps) * longint'(step_ns);
    endfunction

endpackage

// File: rtl/bta_divider.sv
module bta_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  q_r, r_r, d_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {r_r, q_r[W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                q_r <= dividend;
                r_r <= '0;
                d_r <= divisor;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, d_r}) begin
                    r_r <= W'(trial - {1'b0, d_r});
                    q_r <= {q_r[W-2:0], 1'b1};
                end else begin
                    r_r <= trial[W-1:0];
                    q_r <= {q_r[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

    // Remainder of a finished division lies below the divisor (R6, R8).
    assert_div_rem_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (done && d_r != '0) |-> (rem < d_r));

    // A result strobe only follows an active division (R8).
    assert_div_done_after_run_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(run));

endmodule

// File: rtl/bta_extrema.sv
module bta_extrema #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         upd,
    input  logic [W-1:0] base,
    input  logic [W-1:0] cyc,
    output logic         any,
    output logic [W-1:0] earliest,
    output logic [W-1:0] earliest_cyc,
    output logic [W-1:0] latest,
    output logic [W-1:0] longest
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            any          <= 1'b0;
            earliest     <= '1;
            earliest_cyc <= '0;
            latest       <= '0;
            longest      <= '0;
        end else if (upd) begin
            any <= 1'b1;
            if (cyc > longest)
                longest <= cyc;
            if (base > latest)
                latest <= base;
            // Strict compare keeps the lower index on a tie.
            if (!any || base < earliest) begin
                earliest     <= base;
                earliest_cyc <= cyc;
            end
        end
    end

    // The longest cycle never shrinks while samples accumulate (R4).
    assert_longest_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr && $past(!rst && !clr)) |-> (longest >= $past(longest)));

    // The earliest start never exceeds the latest once a sample is held (R5).
    assert_order_R5: assert property (@(posedge clk) disable iff (rst)
        any |-> (earliest <= latest));

endmodule

// File: rtl/base_time_aligner.sv
module base_time_aligner
    import bta_pkg::*;
#(
    parameter int NPORT      = 4,
    parameter int TW         = 32,
    parameter int DELTA_NS   = 200,
    parameter int LIMIT_LOG2 = 19
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    output logic                        busy,
    output logic                        done,
    output logic [$clog2(NPORT)-1:0]    rd_idx,
    input  logic                        rd_valid,
    input  logic [TW-1:0]               rd_base,
    input  logic [TW-1:0]               rd_cycle,
    output logic                        enabled,
    output logic                        range_err,
    output logic [TW-1:0]               earliest_base,
    output logic [TW-1:0]               max_cycle,
    output logic [NPORT*TW-1:0]         entry_deltas
);
    localparam int          IW         = $clog2(NPORT);
    localparam logic [IW-1:0] LAST_IDX = IW'(NPORT - 1);
    localparam logic [TW-1:0] STEP     = TW'(DELTA_NS);
    localparam logic [TW-1:0] SPAN_MAX = TW'(span_limit_ns(LIMIT_LOG2, DELTA_NS));

    bta_state_e    state;
    logic [IW-1:0] idx;
    logic [TW-1:0] delta_q [NPORT];

    // Extremes tracker
    logic          trk_any;
    logic [TW-1:0] trk_early, trk_early_cyc, trk_late, trk_long;

    bta_extrema #(.W(TW)) u_extrema (
        .clk          (clk),
        .rst          (rst),
        .clr          (state == ST_IDLE && start),
        .upd          (state == ST_SCAN && rd_valid),
        .base         (rd_base),
        .cyc          (rd_cycle),
        .any          (trk_any),
        .earliest     (trk_early),
        .earliest_cyc (trk_early_cyc),
        .latest       (trk_late),
        .longest      (trk_long)
    );

    // Shared serial divider
    logic          div_go, div_done;
    logic [TW-1:0] div_a, div_b, div_q, div_r;

    bta_divider #(.W(TW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quot     (div_q),
        .rem      (div_r)
    );

    always_comb begin
        div_go = 1'b0;
        div_a  = '0;
        div_b  = '0;
        case (state)
            ST_SCAN_END: if (trk_any) begin
                div_go = 1'b1;
                div_a  = trk_late - trk_early;
                div_b  = trk_early_cyc;
            end
            ST_PORT: if (rd_valid) begin
                div_go = 1'b1;
                if (rd_base < earliest_base) begin
                    div_a = earliest_base - rd_base;
                    div_b = rd_cycle;
                end else begin
                    div_a = rd_base - earliest_base;
                    div_b = STEP;
                end
            end
            ST_ROLL: if (div_done) begin
                div_go = 1'b1;
                div_a  = (div_r == '0) ? '0 : rd_cycle - div_r;
                div_b  = STEP;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            idx           <= '0;
            enabled       <= 1'b0;
            range_err     <= 1'b0;
            earliest_base <= '0;
            max_cycle     <= '0;
            for (int p = 0; p < NPORT; p++) delta_q[p] <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx           <= '0;
                    enabled       <= 1'b0;
                    range_err     <= 1'b0;
                    earliest_base <= '0;
                    max_cycle     <= '0;
                    for (int p = 0; p < NPORT; p++) delta_q[p] <= '0;
                    state         <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (idx == LAST_IDX) begin
                        idx   <= '0;
                        state <= ST_SCAN_END;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SCAN_END: begin
                    if (trk_any) begin
                        enabled   <= 1'b1;
                        max_cycle <= trk_long;
                        state     <= ST_ALIGN;
                    end else begin
                        state <= ST_DONE;
                    end
                end
                ST_ALIGN: if (div_done) begin
                    // Step back from the latest start by the partial cycle.
                    earliest_base <= trk_late - div_r;
                    if (div_r > SPAN_MAX) begin
                        range_err <= 1'b1;
                        state     <= ST_DONE;
                    end else begin
                        idx   <= '0;
                        state <= ST_PORT;
                    end
                end
                ST_PORT: begin
                    if (!rd_valid) begin
                        if (idx == LAST_IDX) state <= ST_DONE;
                        else idx <= idx + 1'b1;
                    end else if (rd_base < earliest_base) begin
                        state <= ST_ROLL;
                    end else begin
                        state <= ST_QUANT;
                    end
                end
                ST_ROLL: if (div_done) state <= ST_QUANT;
                ST_QUANT: if (div_done) begin
                    delta_q[idx] <= div_q + 1'b1;
                    if (idx == LAST_IDX) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_PORT;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);
    assign rd_idx = idx;

    for (genvar g = 0; g < NPORT; g++) begin : g_pack
        assign entry_deltas[g*TW +: TW] = delta_q[g];
    end

    logic has_unit;
    always_comb begin
        has_unit = 1'b0;
        for (int p = 0; p < NPORT; p++)
            if (delta_q[p] == TW'(1)) has_unit = 1'b1;
    end

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_empty_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !enabled) |-> (entry_deltas == '0 && max_cycle == '0 && !range_err));

    assert_err_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        range_err |-> enabled);

    assert_err_clears_deltas_R7: assert property (@(posedge clk) disable iff (rst)
        (done && range_err) |-> (entry_deltas == '0));

    assert_earliest_gets_one_R8: assert property (@(posedge clk) disable iff (rst)
        (done && enabled && !range_err) |-> has_unit);

endmodule

// File: tb/sim_base_time_aligner.sv
module sim_base_time_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int W  = 32;
    localparam int WD = 2000;
    localparam longint LIMIT = (64'd1 << 19) * 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, enabled, range_err;
    logic [1:0] rd_idx;
    logic [W-1:0] earliest_base, max_cycle;
    logic [NP*W-1:0] entry_deltas;

    logic        v [NP];
    logic [W-1:0] b [NP];
    logic [W-1:0] c [NP];

    int n_chk = 0;
    int n_fail = 0;

    longint e_en, e_err, e_early, e_max;
    longint e_d [NP];
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    base_time_aligner u0 (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .busy          (busy),
        .done          (done),
        .rd_idx        (rd_idx),
        .rd_valid      (v[rd_idx]),
        .rd_base       (b[rd_idx]),
        .rd_cycle      (c[rd_idx]),
        .enabled       (enabled),
        .range_err     (range_err),
        .earliest_base (earliest_base),
        .max_cycle     (max_cycle),
        .entry_deltas  (entry_deltas)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint roll_fwd(input longint bs, input longint cy, input longint now);
        longint n;
        if (bs >= now) return bs;
        n = (now - bs + cy - 1) / cy;
        return bs + n * cy;
    endfunction

    task automatic model();
        longint lat, ear, ec, fb;
        bit any;
        any = 0; lat = 0; ear = 0; ec = 0; e_max = 0;
        for (int p = 0; p < NP; p++) begin
            e_d[p] = 0;
            if (v[p]) begin
                if (longint'(c[p]) > e_max) e_max = c[p];
                if (longint'(b[p]) > lat) lat = b[p];
                if (!any || longint'(b[p]) < ear) begin ear = b[p]; ec = c[p]; end
                any = 1;
            end
        end
        e_en = any; e_err = 0; e_early = 0;
        if (any) begin
            fb = roll_fwd(ear, ec, lat);
            while (fb > lat) fb -= ec;
            e_early = fb;
            e_err = ((lat - fb) > LIMIT);
            if (!e_err)
                for (int p = 0; p < NP; p++)
                    if (v[p]) e_d[p] = (roll_fwd(b[p], c[p], fb) - fb) / 200 + 1;
        end
    endtask

    task automatic run_case(input bit twice);
        int waitn;
        int extra;
        model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R1 busy after start", busy, 1);
        waitn = 0;
        while (done !== 1'b1 && waitn < WD) begin
            start = (twice && waitn == 5);
            @(negedge clk);
            waitn++;
        end
        start = 1'b0;
        chk(waitn < WD, "R1 watchdog", waitn, WD);
        chk(enabled == e_en[0], "R2 enabled", enabled, e_en);
        chk(max_cycle == W'(e_max), "R4 max_cycle", max_cycle, e_max);
        chk(earliest_base == W'(e_early), "R6 earliest_base", earliest_base, e_early);
        chk(range_err == e_err[0], "R7 range_err", range_err, e_err);
        for (int p = 0; p < NP; p++)
            chk(entry_deltas[p*W +: W] == W'(e_d[p]), "R8 R9 entry delta",
                entry_deltas[p*W +: W], e_d[p]);
        if (twice) begin
            @(negedge clk);
            chk(busy === 1'b0, "R1 busy falls after done", busy, 0);
            extra = 0;
            for (int k = 0; k < 40; k++) begin
                if (done) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R1 single done with start while busy", extra, 0);
            chk(earliest_base == W'(e_early), "R9 result held", earliest_base, e_early);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    initial begin
        for (int p = 0; p < NP; p++) begin v[p] = 0; b[p] = 0; c[p] = 1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset idle", busy, 0);
        chk(enabled === 1'b0 && entry_deltas === '0, "R3 reset outputs", enabled, 0);

        // R3: no valid port
        for (int p = 0; p < NP; p++) begin b[p] = 500 * (p + 1); c[p] = 300; end
        run_case(0);

        // R5: tie on earliest start, lower index supplies cycle
        v[0] = 0; v[1] = 1; v[2] = 1; v[3] = 1;
        b[1] = 100; c[1] = 300; b[2] = 100; c[2] = 700; b[3] = 900; c[3] = 700;
        run_case(0);
        chk(earliest_base == 700, "R5 tie alignment", earliest_base, 700);

        // R6: exact multiple, zero remainder
        v[0] = 1; v[1] = 1; v[2] = 0; v[3] = 0;
        b[0] = 1000; c[0] = 400; b[1] = 2200; c[1] = 800;
        run_case(0);

        // R7: span exactly at limit, then one beyond
        v[0] = 1; v[1] = 1; v[2] = 0; v[3] = 1;
        b[0] = 0; c[0] = 200000000; b[1] = W'(LIMIT); c[1] = 200000000;
        b[3] = 5000; c[3] = 200000000;
        run_case(0);
        chk(range_err == 1'b0, "R7 at limit", range_err, 0);
        b[1] = W'(LIMIT + 1);
        run_case(1);
        chk(range_err == 1'b1, "R7 beyond limit", range_err, 1);

        // Sweep of generated configurations
        for (int t = 0; t < 220; t++) begin
            for (int p = 0; p < NP; p++) begin
                seed = nxt(seed); v[p] = seed[20] | seed[7];
                seed = nxt(seed);
                c[p] = seed[3] ? 200 * (1 + (seed[27:16] % 40)) : 1 + (seed[27:12] % 3000);
                seed = nxt(seed);
                b[p] = seed[5] ? (seed[28:8] % 9000) : (seed[30:4] % 32'h0800_0000);
            end
            if (t % 16 == 0) begin
                for (int p = 0; p < NP; p++) c[p] = 120000000;
            end
            run_case(t % 25 == 3);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule